// File: doc/BRIEF.md
# Align-and-Go Spindle Start Sequencer

This block brings a sensorless spindle motor from standstill to a self-commutating state, and runs the same sequence again when a resync is commanded. A command puts the rotor through three timed phases. First one phase pattern is held so that the rotor settles into a known position (align). Then open-loop commutation steps are issued at a fixed rate (go). Last, the drive is released and the block waits a bounded time for a back-EMF zero-crossing pulse, which shows that the rotor is really turning.

A 2-bit delay code, captured when the command arrives, selects one of four align/go duration pairs. The zero-crossing wait is the same for every code. Every duration is a clock-count parameter. The defaults match a 10 MHz clock: align 0.178/0.356/0.533/0.711 s, go 0.711/1.422/2.133/2.844 s, and a 0.419 s wait. A bench can override them with short values.

The block reports the outcome on two status bits. A command raises both bits. If the wait ends without a zero crossing, the go bit drops. If a crossing arrives in time, both bits stay high. The power stage and the zero-crossing detector are outside this block.

Top module: `spin_start_seq`

## Requirements
- R1: While rst_ni is low and after its release, drive_en_o, align_hold_o, step_o, stat_align_o and stat_go_o are 0, phase_o is 0, and the block stays idle until a command arrives.
- R2: When start_i is high at a clock edge, the sequence restarts from any state. From the next cycle align_hold_o, drive_en_o, stat_align_o and stat_go_o are 1 and phase_o is 0.
- R3: align_hold_o is high for exactly ALIGN_CYC_n cycles after the command edge, where n is the value of dly_code_i (0..3) sampled at that edge. Changes of dly_code_i later in the sequence have no effect.
- R4: go follows align and lasts exactly GO_CYC_n cycles for the captured code n. drive_en_o is high for exactly ALIGN_CYC_n + GO_CYC_n cycles and then goes low.
- R5: During go, step_o pulses for one cycle in the first go cycle and then every STEP_CYC cycles, giving ceil(GO_CYC_n / STEP_CYC) pulses. phase_o advances by one, modulo NUM_PHASES, in the cycle after each pulse and holds its value after go.
- R6: A zero-crossing pulse sampled at any edge while the block is waiting, including the last wait cycle, ends the sequence with success. stat_go_o and stat_align_o then stay high.
- R7: If no zero crossing is sampled during the WAIT_CYC wait cycles, stat_go_o falls exactly ALIGN_CYC_n + GO_CYC_n + WAIT_CYC cycles after the command edge. stat_align_o stays high.
- R8: zc_i has no effect outside the wait window: during align, during go, on the edge that ends go, after success and after failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start/resync command, sampled each edge |
| dly_code_i | input | 2 | Align/go duration select, captured with the command |
| zc_i | input | 1 | Back-EMF zero-crossing pulse |
| drive_en_o | output | 1 | Power stage enabled (align and go) |
| align_hold_o | output | 1 | Hold the alignment phase pattern |
| step_o | output | 1 | One-cycle forced-commutation strobe |
| phase_o | output | $clog2(NUM_PHASES) | Commutation phase index |
| stat_align_o | output | 1 | Align status bit |
| stat_go_o | output | 1 | Go status bit; drops on a failed start |

## Verification
All timing is counted from the edge that samples start_i. Call that edge cycle 0. The status bits and align_hold_o change at cycle 0. align_hold_o ends after ALIGN_CYC_n cycles and drive_en_o after ALIGN_CYC_n + GO_CYC_n. On a failed start, stat_go_o falls at cycle ALIGN_CYC_n + GO_CYC_n + WAIT_CYC. A zero crossing counts only if it is sampled at one of the WAIT_CYC edges that follow the end of go. The bench drives inputs on falling edges and samples once per falling edge, starting at cycle 0, so every count and fall index is compared with these sums. The sums are computed from the bench's own table, including zero crossings placed one cycle inside and one cycle outside the window.

// File: rtl/spin_start_pkg.sv
package spin_start_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ALIGN, ST_GO, ST_WAIT, ST_RUN, ST_FAIL
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/spin_start_timer.sv
module spin_start_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/spin_start_stepper.sv
module spin_start_stepper #(
  parameter int STEP_CYC   = 8,
  parameter int NUM_PHASES = 6,
  localparam int PH_W = $clog2(NUM_PHASES),
  localparam int SC_W = $clog2(STEP_CYC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            in_go_i,
  output logic            step_o,
  output logic [PH_W-1:0] phase_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PHASES - 1);

  logic [SC_W-1:0] step_cnt_q;
  logic [PH_W-1:0] phase_q;

  assign step_o  = in_go_i && (step_cnt_q == '0);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    step_cnt_q <= '0;
    else if (clear_i || !in_go_i)   step_cnt_q <= '0;
    else if (step_o)                step_cnt_q <= SC_W'(STEP_CYC - 1);
    else                            step_cnt_q <= step_cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (clear_i)  phase_q <= '0;
    else if (step_o)   phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
  end

  a_r5_phase_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(phase_q) < NUM_PHASES);

  a_r5_step_advances_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !clear_i) |=>
      phase_q == (($past(phase_q) == LAST_PH) ? '0 : $past(phase_q) + 1'b1));

  a_r5_phase_holds_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_o && !clear_i) |=> $stable(phase_q));
endmodule

// File: rtl/spin_start_fsm.sv
module spin_start_fsm
  import spin_start_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ALIGN_CYC_0 = 10,
  parameter int ALIGN_CYC_1 = 20,
  parameter int ALIGN_CYC_2 = 30,
  parameter int ALIGN_CYC_3 = 40,
  parameter int GO_CYC_0    = 50,
  parameter int GO_CYC_1    = 60,
  parameter int GO_CYC_2    = 70,
  parameter int GO_CYC_3    = 80,
  parameter int WAIT_CYC    = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       code_i,
  input  logic             zc_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output seq_state_e       state_o,
  output logic             stat_align_o,
  output logic             stat_go_o
);
  seq_state_e state_q, state_d;
  logic [1:0] code_q;
  logic       align_q, go_q;

  function automatic logic [CNT_W-1:0] align_len(input logic [1:0] c);
    case (c)
      2'd0:    return CNT_W'(ALIGN_CYC_0 - 1);
      2'd1:    return CNT_W'(ALIGN_CYC_1 - 1);
      2'd2:    return CNT_W'(ALIGN_CYC_2 - 1);
      default: return CNT_W'(ALIGN_CYC_3 - 1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] go_len(input logic [1:0] c);
    case (c)
      2'd0:    return CNT_W'(GO_CYC_0 - 1);
      2'd1:    return CNT_W'(GO_CYC_1 - 1);
      2'd2:    return CNT_W'(GO_CYC_2 - 1);
      default: return CNT_W'(GO_CYC_3 - 1);
    endcase
  endfunction

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (start_i) begin
      state_d    = ST_ALIGN;
      tmr_load_o = 1'b1;
      tmr_val_o  = align_len(code_i);
    end else begin
      unique case (state_q)
        ST_ALIGN: if (tmr_done_i) begin
          state_d    = ST_GO;
          tmr_load_o = 1'b1;
          tmr_val_o  = go_len(code_q);
        end
        ST_GO: if (tmr_done_i) begin
          state_d    = ST_WAIT;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(WAIT_CYC - 1);
        end
        ST_WAIT: begin
          if (zc_i)            state_d = ST_RUN;  // crossing wins on last cycle
          else if (tmr_done_i) state_d = ST_FAIL;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      align_q <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i) begin
        code_q  <= code_i;
        align_q <= 1'b1;
        go_q    <= 1'b1;
      end else if (state_q == ST_WAIT && state_d == ST_FAIL) begin
        go_q    <= 1'b0;
      end
    end
  end

  assign state_o      = state_q;
  assign stat_align_o = align_q;
  assign stat_go_o    = go_q;

  a_r2_cmd_enters_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ALIGN) && stat_go_o && stat_align_o);

  a_r7_go_falls_only_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_go_o) |-> (state_q == ST_FAIL));

  a_r7_align_never_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(stat_align_o));

  a_r6_zc_in_wait_succeeds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && zc_i && !start_i) |=> (state_q == ST_RUN));

  a_r8_zc_ignored_while_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ALIGN || state_q == ST_GO) && !tmr_done_i && !start_i) |=> $stable(state_q));

  a_r8_terminal_states_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE || state_q == ST_RUN || state_q == ST_FAIL) && !start_i)
      |=> $stable(state_q) && $stable(stat_go_o));
endmodule

// File: rtl/spin_start_seq.sv
module spin_start_seq
  import spin_start_pkg::*;
#(
  parameter int ALIGN_CYC_0 = 1_780_000,
  parameter int ALIGN_CYC_1 = 3_560_000,
  parameter int ALIGN_CYC_2 = 5_330_000,
  parameter int ALIGN_CYC_3 = 7_110_000,
  parameter int GO_CYC_0    = 7_110_000,
  parameter int GO_CYC_1    = 14_220_000,
  parameter int GO_CYC_2    = 21_330_000,
  parameter int GO_CYC_3    = 28_440_000,
  parameter int WAIT_CYC    = 4_190_000,
  parameter int STEP_CYC    = 20_000,
  parameter int NUM_PHASES  = 6,
  localparam int PH_W = $clog2(NUM_PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      dly_code_i,
  input  logic            zc_i,
  output logic            drive_en_o,
  output logic            align_hold_o,
  output logic            step_o,
  output logic [PH_W-1:0] phase_o,
  output logic            stat_align_o,
  output logic            stat_go_o
);
  localparam int MAX_A = max_of(max_of(ALIGN_CYC_0, ALIGN_CYC_1), max_of(ALIGN_CYC_2, ALIGN_CYC_3));
  localparam int MAX_G = max_of(max_of(GO_CYC_0, GO_CYC_1), max_of(GO_CYC_2, GO_CYC_3));
  localparam int MAX_C = max_of(max_of(MAX_A, MAX_G), WAIT_CYC);
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  seq_state_e       state;

  spin_start_fsm #(
    .CNT_W(CNT_W),
    .ALIGN_CYC_0(ALIGN_CYC_0), .ALIGN_CYC_1(ALIGN_CYC_1),
    .ALIGN_CYC_2(ALIGN_CYC_2), .ALIGN_CYC_3(ALIGN_CYC_3),
    .GO_CYC_0(GO_CYC_0), .GO_CYC_1(GO_CYC_1),
    .GO_CYC_2(GO_CYC_2), .GO_CYC_3(GO_CYC_3),
    .WAIT_CYC(WAIT_CYC)
  ) fsm_i (
    .clk_i, .rst_ni, .start_i,
    .code_i(dly_code_i), .zc_i,
    .tmr_done_i(tmr_done), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .state_o(state), .stat_align_o, .stat_go_o
  );

  spin_start_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .done_o(tmr_done)
  );

  spin_start_stepper #(.STEP_CYC(STEP_CYC), .NUM_PHASES(NUM_PHASES)) stepper_i (
    .clk_i, .rst_ni, .clear_i(start_i), .in_go_i(state == ST_GO),
    .step_o, .phase_o
  );

  assign align_hold_o = (state == ST_ALIGN);
  assign drive_en_o   = (state == ST_ALIGN) || (state == ST_GO);

  a_r4_no_drive_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_go_o |-> !drive_en_o);

  a_r5_step_only_while_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (drive_en_o && !align_hold_o));
endmodule

// File: tb/spin_start_seq_tb_top.sv
module spin_start_seq_tb_top;
  localparam int TA0 = 10, TA1 = 20, TA2 = 30, TA3 = 40;
  localparam int TG0 = 50, TG1 = 60, TG2 = 70, TG3 = 80;
  localparam int TW  = 25;
  localparam int ST  = 8;
  localparam int NP  = 6;

  // code, align cycles, go cycles
  localparam int VEC [4][3] = '{
    '{0, TA0, TG0}, '{1, TA1, TG1}, '{2, TA2, TG2}, '{3, TA3, TG3}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] dly_code_i = 2'd0;
  logic       zc_i = 1'b0;
  logic       drive_en_o, align_hold_o, step_o, stat_align_o, stat_go_o;
  logic [2:0] phase_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  spin_start_seq #(
    .ALIGN_CYC_0(TA0), .ALIGN_CYC_1(TA1), .ALIGN_CYC_2(TA2), .ALIGN_CYC_3(TA3),
    .GO_CYC_0(TG0), .GO_CYC_1(TG1), .GO_CYC_2(TG2), .GO_CYC_3(TG3),
    .WAIT_CYC(TW), .STEP_CYC(ST), .NUM_PHASES(NP)
  ) dut_i (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_start(input int code);
    @(negedge clk_i);
    dly_code_i = 2'(code);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // Called at the falling edge right after the command edge (cycle 0).
  task automatic measure(input int ta, input int tg, input int zc_at);
    int n = ta + tg + TW;
    int acnt = 0, dcnt = 0, steps = 0, fall = -1, ph_end = -1;
    int exp_steps = (tg + ST - 1) / ST;
    int exp_fall = (zc_at >= ta + tg && zc_at <= n - 1) ? -1 : n;
    check("R2", "align_hold at cycle 0", int'(align_hold_o), 1);
    check("R2", "status go at cycle 0", int'(stat_go_o), 1);
    check("R2", "phase at cycle 0", int'(phase_o), 0);
    for (int m = 0; m < n + 40; m++) begin
      if (align_hold_o) acnt++;
      if (drive_en_o) dcnt++;
      if (step_o) steps++;
      if (m == ta + tg) ph_end = int'(phase_o);
      if (!stat_go_o && fall < 0) fall = m;
      zc_i = (m == zc_at);
      @(negedge clk_i);
    end
    zc_i = 1'b0;
    check("R3", "align cycles", acnt, ta);
    check("R4", "drive cycles", dcnt, ta + tg);
    check("R5", "step pulses", steps, exp_steps);
    check("R5", "phase after go", ph_end, exp_steps % NP);
    check(exp_fall < 0 ? "R6" : "R7", "go fall cycle", fall, exp_fall);
    check("R7", "align status kept", int'(stat_align_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    check("R1", "drive in reset", int'(drive_en_o), 0);
    check("R1", "go status in reset", int'(stat_go_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1", "idle outputs after reset",
          int'({drive_en_o, align_hold_o, step_o, stat_align_o, stat_go_o}), 0);
    check("R1", "phase after reset", int'(phase_o), 0);

    // Table walk: every code, no crossing -> failure path.
    for (int v = 0; v < 4; v++) begin
      send_start(VEC[v][0]);
      measure(VEC[v][1], VEC[v][2], -1);
    end

    // R6: crossing on first and on last wait edge.
    send_start(1);
    measure(TA1, TG1, TA1 + TG1);
    send_start(2);
    measure(TA2, TG2, TA2 + TG2 + TW - 1);

    // R8: crossing during align, and on the edge that ends go.
    send_start(0);
    measure(TA0, TG0, 3);
    send_start(3);
    measure(TA3, TG3, TA3 + TG3 - 1);

    // R3: code changed after capture is ignored.
    send_start(0);
    dly_code_i = 2'd3;
    measure(TA0, TG0, -1);

    // R2: restart during go, lengths follow the new code.
    send_start(1);
    repeat (TA1 + 5) @(negedge clk_i);
    check("R2", "in go before restart", int'(drive_en_o && !align_hold_o), 1);
    send_start(2);
    measure(TA2, TG2, -1);

    // R8: crossing after success changes nothing.
    send_start(0);
    measure(TA0, TG0, TA0 + TG0 + 2);
    zc_i = 1'b1;
    @(negedge clk_i);
    zc_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R8", "go after late crossing", int'(stat_go_o), 1);
    check("R8", "drive after late crossing", int'(drive_en_o), 0);

    // R1: asynchronous reset mid-sequence.
    send_start(3);
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", "outputs in mid-run reset",
          int'({drive_en_o, align_hold_o, stat_align_o, stat_go_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1", "idle after mid-run reset", int'(drive_en_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule